// File: doc/BRIEF.md
# Low-Power Mode Control Unit

This block sits beside the processor of a small microcontroller and decides what happens to the chip when the core executes a wait-for-interrupt. Software first picks a target mode through a small register window. When `wfi` arrives, the unit enters one of four states of decreasing power: sleep, deep-sleep, power-down or deep power-down. It then drives the per-domain controls: core clock enable, peripheral clock enable, flash power and flash standby, and the main-domain power switch.

From the three lighter modes, any pending enabled interrupt brings the chip back. The peripheral clock and flash power return at once, and the core clock is held off for a fixed settling window and until the flash reports ready. In deep power-down only the always-on state survives: the four retention registers, the sticky lock bit, the deep power-down flag and the deep power-down control bits. A rising edge on the wake pin or a self wake-up timer tick wakes the chip, and the unit then emits a system reboot pulse before running again.

The register window also keeps entry flags, which are cleared by writing one. It also holds a lock bit that, once set, blocks deep power-down until the next power-on reset.

Top module: `lpm_ctrl`

## Requirements
- R1: The register window decodes word offsets: 0x00 is the power control register, 0x04/0x08/0x0C/0x10 are retention registers 0..3, and 0x14 is the deep power-down control register. The power control register reads mode in [1:0], lock in bit 3, sleep flag in bit 8 and deep power-down flag in bit 11. All other bits of it, bits [31:4] of the deep power-down control register, and every unmapped offset read as zero and ignore writes.
- R2: The retention registers hold any written 32-bit value. They are cleared only by `por_n`: a system reset on `rst_n` and the reboot after deep power-down leave them unchanged. `rst_n` clears the mode field and the sleep flag.
- R3: Writing 1 to bit 3 of the power control register sets the lock. Writes of 0 do not clear it, and only `por_n` does.
- R4: With the lock set, a `wfi` with mode 3 enters power-down behaviour (mode 2) instead of deep power-down, sets the sleep flag and leaves `main_pwr_en` high.
- R5: In sleep (mode 0), only `core_clk_en` is low. The peripheral clock, flash power and main power stay on, and flash standby stays off.
- R6: Deep-sleep (mode 1) drives both clock enables low and holds flash powered in standby. Power-down (mode 2) drives both clock enables low and `flash_pwr_en` low.
- R7: Entry to modes 0..2 sets the sleep flag, and entry to deep power-down sets the deep power-down flag. Writing 1 to a flag's bit clears it, while writing 0 leaves it set. The deep power-down flag survives the reboot.
- R8: When `irq_pend` is seen in modes 0..2, the next cycle restores the peripheral clock and flash power with standby off. `core_clk_en` returns after exactly WAKE_CYC cycles in that state, or later if `flash_rdy` is low, and then in the first cycle after `flash_rdy` is seen high.
- R9: In deep power-down, all domain outputs are low and `irq_pend` is ignored. A wake-pin rising edge (unless the pad is disabled) or a `wake_tick` starts a `sys_reboot` pulse of BOOT_CYC cycles with `flash_rdy` high. The unit then runs with the mode field and sleep flag cleared.
- R10: The deep power-down control bits drive the outputs directly: bit 0 wake-pin hysteresis, bit 1 wake-pad disable (which masks the wake pin in R9), bit 2 low-power oscillator enable, and bit 3 oscillator kept on in deep power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Power-on reset, async active low |
| rst_n | input | 1 | System reset, async active low |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| wfi | input | 1 | Core waits for interrupt |
| irq_pend | input | 1 | Any enabled interrupt pending |
| wake_pin | input | 1 | External wake pin, synchronous |
| wake_tick | input | 1 | Self wake-up timer timeout |
| flash_rdy | input | 1 | Flash powered and ready |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| flash_pwr_en | output | 1 | Flash power switch |
| flash_stby | output | 1 | Flash standby request |
| main_pwr_en | output | 1 | Main domain power switch |
| sys_reboot | output | 1 | System reset request after deep power-down |
| wake_hyst_en | output | 1 | Wake-pin hysteresis enable |
| wake_pad_dis | output | 1 | Wake pad disable |
| lposc_en | output | 1 | Low-power oscillator enable |
| lposc_dpd_en | output | 1 | Oscillator kept on in deep power-down |

## Verification
The hardest situation to reach is the deep power-down round trip. The bench must arm the mode, enter through `wfi`, and prove that interrupts and a masked wake-pin pulse leave the chip off. It must then wake with a tick, measure the reboot pulse width, and read back afterwards that the retention registers and the deep power-down flag survived while the mode field was cleared. The stimulus gets there by programming the pad-disable bit before entry and by counting `sys_reboot` samples cycle by cycle. The lock case is reached the same way, and only a `por_n` pulse clears it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_LP,
    ST_WAKE,
    ST_DPD,
    ST_BOOT
  } lpm_state_e;

  localparam logic [1:0] M_SLEEP  = 2'd0;
  localparam logic [1:0] M_DSLEEP = 2'd1;
  localparam logic [1:0] M_PDOWN  = 2'd2;
  localparam logic [1:0] M_DPD    = 2'd3;

  localparam int PC_LOCK_BIT = 3;
  localparam int PC_SLPF_BIT = 8;
  localparam int PC_DPDF_BIT = 11;
  localparam int DC_W        = 4;

  typedef struct packed {
    logic core_clk;
    logic periph_clk;
    logic flash_pwr;
    logic flash_stby;
    logic main_pwr;
    logic reboot;
  } lpm_gate_t;

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sh_q;
  logic [1:0] sh_d;

  always_comb sh_d = {sh_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[1];

endmodule

// File: rtl/lpm_regs.sv
module lpm_regs
  import lpm_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 5,
  parameter int NUM_GP = 4
) (
  input  logic                clk,
  input  logic                aon_rst_n,
  input  logic                main_rst_n,
  input  logic                reboot_clr,
  input  logic                sel,
  input  logic                wr,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  input  logic                slp_set,
  input  logic                dpd_set,
  output logic [1:0]          mode,
  output logic                lock,
  output logic [DC_W-1:0]     dpdc
);

  localparam int IDX_W   = AW - 2;
  localparam int DPDC_IX = NUM_GP + 1;

  logic [IDX_W-1:0]  idx;
  logic              we;
  logic              pcon_hit;
  logic              dpdc_hit;
  logic [NUM_GP-1:0] gp_hit;

  logic [DW-1:0] gp_q [NUM_GP];
  logic [1:0]    mode_q, mode_d;
  logic          slpf_q, slpf_d;
  logic          lock_q, lock_d;
  logic          dpdf_q, dpdf_d;
  logic [DC_W-1:0] dpdc_q, dpdc_d;
  logic [DW-1:0] pcon_rd;

  assign idx      = addr[AW-1:2];
  assign we       = sel & wr;
  assign pcon_hit = we && (idx == IDX_W'(0));
  assign dpdc_hit = we && (idx == IDX_W'(DPDC_IX));

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp_dec
    assign gp_hit[g] = we && (idx == IDX_W'(g + 1));
  end

  // next-state logic
  always_comb begin
    mode_d = mode_q;
    if (reboot_clr)    mode_d = M_SLEEP;
    else if (pcon_hit) mode_d = wdata[1:0];

    slpf_d = slpf_q;
    if (reboot_clr)                        slpf_d = 1'b0;
    else if (slp_set)                      slpf_d = 1'b1;
    else if (pcon_hit && wdata[PC_SLPF_BIT]) slpf_d = 1'b0;

    lock_d = lock_q | (pcon_hit & wdata[PC_LOCK_BIT]);

    dpdf_d = dpdf_q;
    if (dpd_set)                             dpdf_d = 1'b1;
    else if (pcon_hit && wdata[PC_DPDF_BIT]) dpdf_d = 1'b0;

    dpdc_d = dpdc_hit ? wdata[DC_W-1:0] : dpdc_q;
  end

  // main domain: lost on system reset and on reboot
  always_ff @(posedge clk or negedge main_rst_n) begin
    if (!main_rst_n) begin
      mode_q <= M_SLEEP;
      slpf_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      slpf_q <= slpf_d;
    end
  end

  // always-on domain: cleared only at power-on
  always_ff @(posedge clk or negedge aon_rst_n) begin
    if (!aon_rst_n) begin
      lock_q <= 1'b0;
      dpdf_q <= 1'b0;
      dpdc_q <= '0;
      for (int i = 0; i < NUM_GP; i++) gp_q[i] <= '0;
    end else begin
      lock_q <= lock_d;
      dpdf_q <= dpdf_d;
      dpdc_q <= dpdc_d;
      for (int i = 0; i < NUM_GP; i++) begin
        if (gp_hit[i]) gp_q[i] <= wdata;
      end
    end
  end

  always_comb begin
    pcon_rd              = '0;
    pcon_rd[1:0]         = mode_q;
    pcon_rd[PC_LOCK_BIT] = lock_q;
    pcon_rd[PC_SLPF_BIT] = slpf_q;
    pcon_rd[PC_DPDF_BIT] = dpdf_q;
  end

  always_comb begin
    rdata = '0;
    if (sel && !wr) begin
      if (idx == IDX_W'(0))       rdata = pcon_rd;
      if (idx == IDX_W'(DPDC_IX)) rdata = DW'(dpdc_q);
      for (int i = 0; i < NUM_GP; i++) begin
        if (idx == IDX_W'(i + 1)) rdata = gp_q[i];
      end
    end
  end

  assign mode = mode_q;
  assign lock = lock_q;
  assign dpdc = dpdc_q;

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!aon_rst_n)
    lock_q |=> lock_q);

  p_dpd_flag_hold_r7: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (dpdf_q && !(pcon_hit && wdata[PC_DPDF_BIT])) |=> dpdf_q);

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int WAKE_CYC = 4,
  parameter int BOOT_CYC = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wfi,
  input  logic      irq,
  input  logic      wake_pin,
  input  logic      wake_tick,
  input  logic      flash_rdy,
  input  logic [1:0] mode,
  input  logic      lock,
  input  logic      pad_dis,
  output logic      slp_set,
  output logic      dpd_set,
  output lpm_gate_t gate
);

  localparam int CNT_MAX = (WAKE_CYC > BOOT_CYC) ? WAKE_CYC : BOOT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  lpm_state_e       st_q, st_d;
  logic [1:0]       lpm_q, lpm_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pin_q;
  logic [1:0]       eff_mode;
  logic             wake_ev;

  assign eff_mode = (mode == M_DPD && lock) ? M_PDOWN : mode;
  assign wake_ev  = (wake_pin & ~pin_q & ~pad_dis) | wake_tick;

  always_comb begin
    st_d    = st_q;
    lpm_d   = lpm_q;
    cnt_d   = cnt_q;
    slp_set = 1'b0;
    dpd_set = 1'b0;
    case (st_q)
      ST_RUN: if (wfi) begin
        if (eff_mode == M_DPD) begin
          st_d    = ST_DPD;
          dpd_set = 1'b1;
        end else begin
          st_d    = ST_LP;
          lpm_d   = eff_mode;
          slp_set = 1'b1;
        end
      end
      ST_LP: if (irq) begin
        st_d  = ST_WAKE;
        cnt_d = '0;
      end
      ST_WAKE: begin
        if (cnt_q == CNT_W'(WAKE_CYC - 1)) begin
          if (flash_rdy) st_d = ST_RUN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DPD: if (wake_ev) begin
        st_d  = ST_BOOT;
        cnt_d = '0;
      end
      ST_BOOT: begin
        if (cnt_q == CNT_W'(BOOT_CYC - 1)) begin
          if (flash_rdy) st_d = ST_RUN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      lpm_q <= M_SLEEP;
      cnt_q <= '0;
      pin_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      lpm_q <= lpm_d;
      cnt_q <= cnt_d;
      pin_q <= wake_pin;
    end
  end

  always_comb begin
    gate = '{core_clk: 1'b1, periph_clk: 1'b1, flash_pwr: 1'b1,
             flash_stby: 1'b0, main_pwr: 1'b1, reboot: 1'b0};
    case (st_q)
      ST_LP: begin
        gate.core_clk   = 1'b0;
        gate.periph_clk = (lpm_q == M_SLEEP);
        gate.flash_pwr  = (lpm_q != M_PDOWN);
        gate.flash_stby = (lpm_q == M_DSLEEP);
      end
      ST_WAKE: gate.core_clk = 1'b0;
      ST_DPD: gate = '0;
      ST_BOOT: begin
        gate.core_clk   = 1'b0;
        gate.periph_clk = 1'b0;
        gate.reboot     = 1'b1;
      end
      default: ;
    endcase
  end

  p_lock_blocks_dpd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && wfi && lock) |=> (st_q != ST_DPD));

  p_irq_ignored_dpd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DPD && !wake_tick && !(wake_pin && !pin_q && !pad_dis)) |=> (st_q == ST_DPD));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 5,
  parameter int NUM_GP   = 4,
  parameter int WAKE_CYC = 4,
  parameter int BOOT_CYC = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          wfi,
  input  logic          irq_pend,
  input  logic          wake_pin,
  input  logic          wake_tick,
  input  logic          flash_rdy,
  output logic          core_clk_en,
  output logic          periph_clk_en,
  output logic          flash_pwr_en,
  output logic          flash_stby,
  output logic          main_pwr_en,
  output logic          sys_reboot,
  output logic          wake_hyst_en,
  output logic          wake_pad_dis,
  output logic          lposc_en,
  output logic          lposc_dpd_en
);

  logic            aon_srst_n;
  logic            main_srst_n;
  logic            main_arst_n;
  logic [1:0]      mode;
  logic            lock;
  logic [DC_W-1:0] dpdc;
  logic            slp_set, dpd_set;
  lpm_gate_t       gate;

  assign main_arst_n = por_n & rst_n;

  lpm_rst_sync u_aon_rst  (.clk(clk), .arst_n(por_n),       .srst_n(aon_srst_n));
  lpm_rst_sync u_main_rst (.clk(clk), .arst_n(main_arst_n), .srst_n(main_srst_n));

  lpm_regs #(.DW(DW), .AW(AW), .NUM_GP(NUM_GP)) u_regs (
    .clk(clk), .aon_rst_n(aon_srst_n), .main_rst_n(main_srst_n),
    .reboot_clr(gate.reboot), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .slp_set(slp_set), .dpd_set(dpd_set),
    .mode(mode), .lock(lock), .dpdc(dpdc)
  );

  lpm_seq #(.WAKE_CYC(WAKE_CYC), .BOOT_CYC(BOOT_CYC)) u_seq (
    .clk(clk), .rst_n(aon_srst_n), .wfi(wfi), .irq(irq_pend),
    .wake_pin(wake_pin), .wake_tick(wake_tick), .flash_rdy(flash_rdy),
    .mode(mode), .lock(lock), .pad_dis(dpdc[1]),
    .slp_set(slp_set), .dpd_set(dpd_set), .gate(gate)
  );

  assign core_clk_en   = gate.core_clk;
  assign periph_clk_en = gate.periph_clk;
  assign flash_pwr_en  = gate.flash_pwr;
  assign flash_stby    = gate.flash_stby;
  assign main_pwr_en   = gate.main_pwr;
  assign sys_reboot    = gate.reboot;
  assign wake_hyst_en  = dpdc[0];
  assign wake_pad_dis  = dpdc[1];
  assign lposc_en      = dpdc[2];
  assign lposc_dpd_en  = dpdc[3];

  p_core_after_rdy_r8: assert property (@(posedge clk) disable iff (!aon_srst_n)
    $rose(core_clk_en) |-> $past(flash_rdy));

  p_dpd_all_off_r9: assert property (@(posedge clk) disable iff (!aon_srst_n)
    !main_pwr_en |-> (!core_clk_en && !periph_clk_en && !flash_pwr_en));

endmodule

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;

  localparam int WAKE_N = 4;
  localparam int BOOT_N = 8;
  localparam logic [4:0] A_PC  = 5'h00;
  localparam logic [4:0] A_GP0 = 5'h04;
  localparam logic [4:0] A_DC  = 5'h14;

  logic clk = 1'b0;
  logic por_n, rst_n, bus_sel, bus_wr, wfi, irq_pend, wake_pin, wake_tick, flash_rdy;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic core_clk_en, periph_clk_en, flash_pwr_en, flash_stby, main_pwr_en, sys_reboot;
  logic wake_hyst_en, wake_pad_dis, lposc_en, lposc_dpd_en;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  lpm_ctrl #(.WAKE_CYC(WAKE_N), .BOOT_CYC(BOOT_N)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [4:0] gates();
    return {core_clk_en, periph_clk_en, flash_pwr_en, flash_stby, main_pwr_en};
  endfunction

  task automatic enter_wfi();
    wfi = 1'b1;
    @(negedge clk);
    wfi = 1'b0;
  endtask

  task automatic wake_irq(input string req);
    irq_pend = 1'b1;
    @(negedge clk);
    irq_pend = 1'b0;
    check({req, " wake restores clocks and flash"}, gates(), 5'b01101);
    repeat (WAKE_N - 1) @(negedge clk);
    check({req, " core still held"}, core_clk_en, 1'b0);
    @(negedge clk);
    check({req, " core restarts"}, core_clk_en, 1'b1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 reset gates", gates(), 5'b11101);
    bus_read(A_PC, d);  check("R1 reset pcon", d, 32'h0);
    bus_read(A_GP0, d); check("R2 reset gp0", d, 32'h0);
    bus_read(A_DC, d);  check("R1 reset dpdc", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) bus_write(5'(4 + 4 * i), 32'hA5000000 + 32'(i * 17));
    for (int i = 0; i < 4; i++) begin
      bus_read(5'(4 + 4 * i), d);
      check("R2 gp readback", d, 32'hA5000000 + 32'(i * 17));
    end
    bus_write(A_PC, 32'hFFFF_F6F2);
    bus_read(A_PC, d); check("R1 pcon reserved masked", d, 32'h2);
    bus_write(A_DC, 32'hFFFF_FFF5);
    bus_read(A_DC, d); check("R1 dpdc reserved masked", d, 32'h5);
    check("R10 dpdc outputs", {lposc_dpd_en, lposc_en, wake_pad_dis, wake_hyst_en}, 4'b0101);
    bus_write(A_DC, 32'h0000_000A);
    check("R10 dpdc outputs 2", {lposc_dpd_en, lposc_en, wake_pad_dis, wake_hyst_en}, 4'b1010);
    bus_write(A_DC, 32'h0);
    bus_write(5'h18, 32'hFFFF_FFFF);
    bus_read(5'h18, d); check("R1 unmapped reads zero", d, 32'h0);
  endtask

  task automatic t_sleep();
    logic [31:0] d;
    bus_write(A_PC, 32'h0);
    enter_wfi();
    check("R5 sleep gates", gates(), 5'b01101);
    bus_read(A_PC, d); check("R7 sleep flag set", d, 32'h100);
    wake_irq("R8 sleep");
    bus_write(A_PC, 32'h0);
    bus_read(A_PC, d); check("R7 write zero keeps flag", d, 32'h100);
    bus_write(A_PC, 32'h100);
    bus_read(A_PC, d); check("R7 w1c clears flag", d, 32'h0);
  endtask

  task automatic t_deepsleep();
    bus_write(A_PC, 32'h1);
    enter_wfi();
    check("R6 deep-sleep gates", gates(), 5'b00111);
    flash_rdy = 1'b0;
    irq_pend = 1'b1;
    @(negedge clk);
    irq_pend = 1'b0;
    check("R8 periph released", periph_clk_en, 1'b1);
    repeat (WAKE_N + 2) @(negedge clk);
    check("R8 core waits for flash", core_clk_en, 1'b0);
    flash_rdy = 1'b1;
    @(negedge clk);
    check("R8 core after flash ready", core_clk_en, 1'b1);
    bus_write(A_PC, 32'h100);
  endtask

  task automatic t_powerdown();
    bus_write(A_PC, 32'h2);
    enter_wfi();
    check("R6 power-down gates", gates(), 5'b00001);
    wake_irq("R8 power-down");
  endtask

  task automatic t_sysrst();
    logic [31:0] d;
    bus_write(A_PC, 32'h2);
    enter_wfi();
    wake_irq("R8 pre-reset");
    bus_write(A_DC, 32'h4);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(A_PC, d); check("R2 rst clears mode and sleep flag", d, 32'h0);
    bus_read(A_GP0, d); check("R2 gp kept over rst", d, 32'hA5000000);
    bus_read(A_DC, d); check("R2 dpdc kept over rst", d, 32'h4);
  endtask

  task automatic t_dpd_tick();
    logic [31:0] d;
    int cnt;
    bus_write(A_DC, 32'h2);
    bus_write(A_PC, 32'h3);
    enter_wfi();
    check("R9 dpd all off", {gates(), sys_reboot}, 6'b0);
    bus_read(A_PC, d); check("R7 dpd flag set", d, 32'h803);
    irq_pend = 1'b1;
    repeat (3) @(negedge clk);
    irq_pend = 1'b0;
    check("R9 irq ignored in dpd", main_pwr_en, 1'b0);
    wake_pin = 1'b1;
    @(negedge clk);
    wake_pin = 1'b0;
    @(negedge clk);
    check("R10 disabled pad ignores pin", main_pwr_en, 1'b0);
    wake_tick = 1'b1;
    @(negedge clk);
    wake_tick = 1'b0;
    cnt = 0;
    while (sys_reboot && cnt < 50) begin
      cnt++;
      @(negedge clk);
    end
    check("R9 reboot pulse width", 32'(cnt), 32'(BOOT_N));
    check("R9 running after reboot", gates(), 5'b11101);
    bus_read(A_PC, d); check("R9 mode cleared, dpd flag kept", d, 32'h800);
    bus_read(A_GP0, d); check("R2 gp kept over dpd", d, 32'hA5000000);
  endtask

  task automatic t_dpd_pin();
    logic [31:0] d;
    bus_write(A_DC, 32'h0);
    bus_write(A_PC, 32'h800);
    bus_read(A_PC, d); check("R7 dpd flag w1c", d, 32'h0);
    bus_write(A_PC, 32'h3);
    enter_wfi();
    check("R9 dpd entered", main_pwr_en, 1'b0);
    wake_pin = 1'b1;
    @(negedge clk);
    check("R9 pin edge reboots", sys_reboot, 1'b1);
    wake_pin = 1'b0;
    repeat (BOOT_N) @(negedge clk);
    check("R9 pin wake runs", gates(), 5'b11101);
    bus_write(A_PC, 32'h800);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    bus_write(A_PC, 32'hB);
    bus_read(A_PC, d); check("R3 lock set", d, 32'hB);
    bus_write(A_PC, 32'h3);
    bus_read(A_PC, d); check("R3 lock sticky", d, 32'hB);
    enter_wfi();
    check("R4 locked mode3 acts as power-down", gates(), 5'b00001);
    bus_read(A_PC, d); check("R4 sleep flag not dpd flag", d, 32'h10B);
    wake_irq("R8 locked");
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(A_PC, d); check("R3 por clears lock", d, 32'h0);
    bus_read(A_GP0, d); check("R2 por clears gp", d, 32'h0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; wfi = 1'b0; irq_pend = 1'b0; wake_pin = 1'b0; wake_tick = 1'b0;
    flash_rdy = 1'b1;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_sleep();
    t_deepsleep();
    t_powerdown();
    t_sysrst();
    t_dpd_tick();
    t_dpd_pin();
    t_lock();
    finish_run();
  end

endmodule